// File: doc/BRIEF.md
# Next-PC Predecoder for a Mixed 16/32/48-bit Instruction Set

The block looks at one 16-bit instruction halfword of a compact 32-bit instruction set, together with the 32-bit word stored right after it and the address of the halfword. It sorts the halfword into one of three forms and works out the instruction length in bytes. It then reports up to two candidate next-PC values, each with its own valid flag. A single-step or trace engine uses these candidates to decide where execution can go next, without executing the instruction.

Most instructions resolve at once. Two kinds depend on machine state. A register-indirect jump needs the value of a general register, and a return needs the saved return address, which sits in memory at the frame pointer plus 4. For these the block issues one read request on a request/response channel. It stays busy until the data comes back, and then completes the result. System-call and break instructions produce no candidate and raise an unsupported flag.

Top module: `npc_predecode`

## Requirements
- R1: A halfword is accepted on a clock edge where `inValid` is high and `busy` is low. For an immediately resolvable instruction the result appears in the next cycle with `resValid` high for that single cycle. After reset every result output and `busy` are low.
- R2: When bit 15 is 0 the halfword is form 1, with opcode bits 15:8. Form-1 opcodes with no other rule below are 2 bytes long with candidate 0 = PC+2. Every halfword with bits 15:14 = 10 (form 2) is also 2 bytes long with candidate 0 = PC+2.
- R3: Form-1 opcodes 0x0c, 0x0d, 0x36, 0x37, 0x38 and 0x39 are 4 bytes long with candidate 0 = PC+4.
- R4: Form-1 opcodes 0x01, 0x08, 0x09, 0x1b, 0x1d, 0x1f, 0x20, 0x22 and 0x24 are 6 bytes long with candidate 0 = PC+6.
- R5: When bits 15:14 = 11 the halfword is form 3, with opcode bits 13:10. Opcodes 0 to 9 report both candidates as valid: candidate 0 = PC+2, and candidate 1 = PC+2 + (bits 9:0 sign-extended, shifted left by one). Length is 2.
- R6: Form-3 opcodes 10 to 15 report no valid candidate, with length 2 and the unsupported flag low.
- R7: Form-1 opcodes 0x03 and 0x1a are 6 bytes long, and candidate 0 is the trailing 32-bit word.
- R8: Form-1 opcodes 0x19 and 0x25 issue a register read: `rdReqIsMem` = 0 and `rdReqAddr` = bits 7:4 of the halfword. The result then has candidate 0 = `rdRspData`, valid, with length 2.
- R9: Form-1 opcode 0x04 issues a memory read: `rdReqIsMem` = 1 and `rdReqAddr` = `framePtr` + 4. The result then has candidate 0 = `rdRspData`, valid, with length 2.
- R10: Form-1 opcodes 0x30 (length 6) and 0x35 (length 2) give no valid candidate and set `resUnsupported`.
- R11: From accept until the read data returns, `busy` is high, and any halfword presented is ignored. `rdReqValid` with its address and kind stays steady until `rdReqReady` is seen. The response counts only after the request has been taken, and the result follows it one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Halfword present for decoding |
| halfword | input | 16 | Instruction halfword |
| trailWord | input | 32 | Word following the halfword |
| pc | input | 32 | Address of the halfword |
| framePtr | input | 32 | Current frame pointer value |
| busy | output | 1 | A read is outstanding; input ignored |
| rdReqValid | output | 1 | Read request pending |
| rdReqReady | input | 1 | Read request taken |
| rdReqIsMem | output | 1 | 1 = memory read, 0 = register read |
| rdReqAddr | output | 32 | Memory address or register index |
| rdRspValid | input | 1 | Read data returned |
| rdRspData | input | 32 | Returned read data |
| resValid | output | 1 | One-cycle result strobe |
| resLen | output | 3 | Instruction length in bytes |
| resPc0 | output | 32 | Candidate 0 (sequential or resolved target) |
| resPc0Valid | output | 1 | Candidate 0 valid |
| resPc1 | output | 32 | Candidate 1 (branch target) |
| resPc1Valid | output | 1 | Candidate 1 valid |
| resUnsupported | output | 1 | System call or break seen |

## Verification
An immediately resolvable halfword shows its result one edge after it is accepted. A read request is raised one edge after accept and holds until `rdReqReady` is high on an edge. The completed result appears one edge after the edge that sees `rdRspValid`. The bench drives every input on the falling edge and samples on the following falling edge, counting exactly one rising edge per step. The deferred cases stall `rdReqReady` for two cycles and present a new halfword during the stall. The cycle after completion is then checked to confirm that this halfword left no result behind.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {KIND_DONE, KIND_REG, KIND_MEM} deferKind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} ctlState_e;

  typedef struct packed {
    logic loadDecode;
    logic latchPending;
    logic loadResponse;
  } ctlStrobe_t;

  localparam int unsigned LEN_W = 3;
  localparam logic [3:0] LAST_COND_BRANCH = 4'd9;
endpackage

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [15:0]      halfword,
  input  logic [AW-1:0]    trailWord,
  input  logic [AW-1:0]    pc,
  input  logic [AW-1:0]    framePtr,
  input  logic [AW-1:0]    rdRspData,
  input  ctlStrobe_t       strobe,
  output deferKind_e       decKind,
  output logic             rdReqIsMem,
  output logic [AW-1:0]    rdReqAddr,
  output logic             resValid,
  output logic [LEN_W-1:0] resLen,
  output logic [AW-1:0]    resPc0,
  output logic             resPc0Valid,
  output logic [AW-1:0]    resPc1,
  output logic             resPc1Valid,
  output logic             resUnsupported
);
  logic [7:0]       opWide;
  logic [3:0]       opNarrow;
  logic [AW-1:0]    seqNext;
  logic [AW-1:0]    branchOff;
  logic [LEN_W-1:0] dLen;
  logic [AW-1:0]    dPc0, dPc1, dReqAddr;
  logic             dV0, dV1, dUnsup, dReqIsMem;
  logic [LEN_W-1:0] pendLen;

  assign opWide    = halfword[15:8];
  assign opNarrow  = halfword[13:10];
  assign seqNext   = pc + AW'(2);
  assign branchOff = {{(AW-11){halfword[9]}}, halfword[9:0], 1'b0};

  always_comb begin
    decKind   = KIND_DONE;
    dLen      = LEN_W'(2);
    dPc0      = seqNext;
    dV0       = 1'b1;
    dPc1      = '0;
    dV1       = 1'b0;
    dUnsup    = 1'b0;
    dReqAddr  = framePtr + AW'(4);
    dReqIsMem = 1'b1;
    if (!halfword[15]) begin
      case (opWide)
        8'h0c, 8'h0d, 8'h36, 8'h37, 8'h38, 8'h39: begin
          dLen = LEN_W'(4);
          dPc0 = pc + AW'(4);
        end
        8'h01, 8'h08, 8'h09, 8'h1b, 8'h1d, 8'h1f, 8'h20, 8'h22, 8'h24: begin
          dLen = LEN_W'(6);
          dPc0 = pc + AW'(6);
        end
        8'h03, 8'h1a: begin
          dLen = LEN_W'(6);
          dPc0 = trailWord;
        end
        8'h19, 8'h25: begin
          decKind   = KIND_REG;
          dV0       = 1'b0;
          dReqIsMem = 1'b0;
          dReqAddr  = AW'(halfword[7:4]);
        end
        8'h04: begin
          decKind = KIND_MEM;
          dV0     = 1'b0;
        end
        8'h30: begin
          dLen   = LEN_W'(6);
          dV0    = 1'b0;
          dUnsup = 1'b1;
        end
        8'h35: begin
          dV0    = 1'b0;
          dUnsup = 1'b1;
        end
        default: ;
      endcase
    end else if (halfword[14]) begin
      if (opNarrow <= LAST_COND_BRANCH) begin
        dV1  = 1'b1;
        dPc1 = seqNext + branchOff;
      end else begin
        dV0 = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid       <= 1'b0;
      resLen         <= '0;
      resPc0         <= '0;
      resPc0Valid    <= 1'b0;
      resPc1         <= '0;
      resPc1Valid    <= 1'b0;
      resUnsupported <= 1'b0;
      pendLen        <= '0;
      rdReqAddr      <= '0;
      rdReqIsMem     <= 1'b0;
    end else begin
      resValid <= strobe.loadDecode | strobe.loadResponse;
      if (strobe.loadDecode) begin
        resLen         <= dLen;
        resPc0         <= dPc0;
        resPc0Valid    <= dV0;
        resPc1         <= dPc1;
        resPc1Valid    <= dV1;
        resUnsupported <= dUnsup;
      end
      if (strobe.latchPending) begin
        pendLen    <= dLen;
        rdReqAddr  <= dReqAddr;
        rdReqIsMem <= dReqIsMem;
      end
      if (strobe.loadResponse) begin
        resLen         <= pendLen;
        resPc0         <= rdRspData;
        resPc0Valid    <= 1'b1;
        resPc1         <= '0;
        resPc1Valid    <= 1'b0;
        resUnsupported <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/npc_control.sv
module npc_control
  import npc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  deferKind_e decKind,
  input  logic       rdReqReady,
  input  logic       rdRspValid,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       rdReqValid
);
  ctlState_e state, stateNext;
  logic      accept;

  assign accept     = inValid && (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign rdReqValid = (state == ST_REQ);

  always_comb begin
    strobe.loadDecode   = accept && (decKind == KIND_DONE);
    strobe.latchPending = accept && (decKind != KIND_DONE);
    strobe.loadResponse = (state == ST_WAIT) && rdRspValid;
    stateNext = state;
    case (state)
      ST_IDLE: if (strobe.latchPending) stateNext = ST_REQ;
      ST_REQ:  if (rdReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (rdRspValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/npc_predecode.sv
module npc_predecode
  import npc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [15:0]      halfword,
  input  logic [AW-1:0]    trailWord,
  input  logic [AW-1:0]    pc,
  input  logic [AW-1:0]    framePtr,
  output logic             busy,
  output logic             rdReqValid,
  input  logic             rdReqReady,
  output logic             rdReqIsMem,
  output logic [AW-1:0]    rdReqAddr,
  input  logic             rdRspValid,
  input  logic [AW-1:0]    rdRspData,
  output logic             resValid,
  output logic [LEN_W-1:0] resLen,
  output logic [AW-1:0]    resPc0,
  output logic             resPc0Valid,
  output logic [AW-1:0]    resPc1,
  output logic             resPc1Valid,
  output logic             resUnsupported
);
  ctlStrobe_t strobe;
  deferKind_e decKind;

  npc_control uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .decKind(decKind),
    .rdReqReady(rdReqReady), .rdRspValid(rdRspValid),
    .strobe(strobe), .busy(busy), .rdReqValid(rdReqValid)
  );

  npc_datapath #(.AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .halfword(halfword), .trailWord(trailWord),
    .pc(pc), .framePtr(framePtr), .rdRspData(rdRspData), .strobe(strobe),
    .decKind(decKind), .rdReqIsMem(rdReqIsMem), .rdReqAddr(rdReqAddr),
    .resValid(resValid), .resLen(resLen), .resPc0(resPc0),
    .resPc0Valid(resPc0Valid), .resPc1(resPc1), .resPc1Valid(resPc1Valid),
    .resUnsupported(resUnsupported)
  );
endmodule

// File: rtl/npc_predecode_chk.sv
module npc_predecode_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          busy,
  input logic          rdReqValid,
  input logic          rdReqReady,
  input logic          rdReqIsMem,
  input logic [AW-1:0] rdReqAddr,
  input logic          rdRspValid,
  input logic          resValid,
  input logic [2:0]    resLen,
  input logic          resPc0Valid,
  input logic          resPc1Valid,
  input logic          resUnsupported
);
  // R1
  accept_progress_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !busy |=> resValid || busy);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReqValid && !rdReqReady |=> rdReqValid && $stable(rdReqAddr) && $stable(rdReqIsMem));

  // R11
  quiet_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !resValid);

  // R8
  rsp_completes_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !rdReqValid && rdRspValid |=> resValid && resPc0Valid && !busy);

  // R5
  branch_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resPc1Valid |-> resPc0Valid && resLen == 3'd2);

  // R10
  unsup_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resUnsupported |-> !resPc0Valid && !resPc1Valid);
endmodule

bind npc_predecode npc_predecode_chk #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .busy(busy),
  .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqIsMem(rdReqIsMem),
  .rdReqAddr(rdReqAddr), .rdRspValid(rdRspValid), .resValid(resValid),
  .resLen(resLen), .resPc0Valid(resPc0Valid), .resPc1Valid(resPc1Valid),
  .resUnsupported(resUnsupported)
);

// File: tb/tb_npc_predecode.sv
module tb_npc_predecode;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  // {halfword, trailWord, len, v0, pc0, v1, pc1, unsupported}; pc = 0x1000
  localparam logic [117:0] VEC [NVEC] = '{
    {16'h0f00, 32'h0,        3'd2, 1'b1, 32'h1002,     1'b0, 32'h0,    1'b0}, // R2 form-1 default
    {16'h8512, 32'h0,        3'd2, 1'b1, 32'h1002,     1'b0, 32'h0,    1'b0}, // R2 form 2
    {16'h0c12, 32'h0,        3'd4, 1'b1, 32'h1004,     1'b0, 32'h0,    1'b0}, // R3
    {16'h3900, 32'h0,        3'd4, 1'b1, 32'h1004,     1'b0, 32'h0,    1'b0}, // R3
    {16'h0123, 32'h0,        3'd6, 1'b1, 32'h1006,     1'b0, 32'h0,    1'b0}, // R4
    {16'h2400, 32'h0,        3'd6, 1'b1, 32'h1006,     1'b0, 32'h0,    1'b0}, // R4
    {16'hc003, 32'h0,        3'd2, 1'b1, 32'h1002,     1'b1, 32'h1008, 1'b0}, // R5 forward
    {16'he7ff, 32'h0,        3'd2, 1'b1, 32'h1002,     1'b1, 32'h1000, 1'b0}, // R5 op 9, -2
    {16'hd600, 32'h0,        3'd2, 1'b1, 32'h1002,     1'b1, 32'h0c02, 1'b0}, // R5 min offset
    {16'he800, 32'h0,        3'd2, 1'b0, 32'h1002,     1'b0, 32'h0,    1'b0}, // R6 op 10
    {16'hfc00, 32'h0,        3'd2, 1'b0, 32'h1002,     1'b0, 32'h0,    1'b0}, // R6 op 15
    {16'h0300, 32'hdeadbee0, 3'd6, 1'b1, 32'hdeadbee0, 1'b0, 32'h0,    1'b0}, // R7
    {16'h1a00, 32'h00002000, 3'd6, 1'b1, 32'h00002000, 1'b0, 32'h0,    1'b0}, // R7
    {16'h3000, 32'h0,        3'd6, 1'b0, 32'h1002,     1'b0, 32'h0,    1'b1}, // R10
    {16'h3500, 32'h0,        3'd2, 1'b0, 32'h1002,     1'b0, 32'h0,    1'b1}  // R10
  };

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic [15:0] halfword = '0;
  logic [31:0] trailWord = '0, pc = 32'h1000, framePtr = 32'h8000, rdRspData = '0;
  logic rdReqReady = 1'b0, rdRspValid = 1'b0;
  logic busy, rdReqValid, rdReqIsMem, resValid, resPc0Valid, resPc1Valid, resUnsupported;
  logic [31:0] rdReqAddr, resPc0, resPc1;
  logic [2:0] resLen;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_predecode dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .halfword(halfword),
    .trailWord(trailWord), .pc(pc), .framePtr(framePtr), .busy(busy),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqIsMem(rdReqIsMem),
    .rdReqAddr(rdReqAddr), .rdRspValid(rdRspValid), .rdRspData(rdRspData),
    .resValid(resValid), .resLen(resLen), .resPc0(resPc0),
    .resPc0Valid(resPc0Valid), .resPc1(resPc1), .resPc1Valid(resPc1Valid),
    .resUnsupported(resUnsupported)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // compares the full result bundle; candidate values only when flagged valid
  task automatic checkRes(input string req, input logic [2:0] len, input logic v0,
                          input logic [31:0] p0, input logic v1, input logic [31:0] p1,
                          input logic uns);
    check({req, " valid"}, 64'(resValid), 64'(1));
    check({req, " flags"}, 64'({resLen, resPc0Valid, resPc1Valid, resUnsupported}),
          64'({len, v0, v1, uns}));
    if (v0) check({req, " pc0"}, 64'(resPc0), 64'(p0));
    if (v1) check({req, " pc1"}, 64'(resPc1), 64'(p1));
  endtask

  task automatic deferred(input string req, input logic [15:0] hw, input logic isMem,
                          input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk); halfword = hw; inValid = 1'b1;
    @(negedge clk);
    check({req, " request"}, 64'({rdReqValid, rdReqIsMem, busy, resValid}),
          64'({1'b1, isMem, 1'b1, 1'b0}));
    check({req, " address"}, 64'(rdReqAddr), 64'(addr));
    halfword = 16'h0f00;  // R11: presented while busy, must be ignored
    @(negedge clk);
    check({req, " R11 hold"}, 64'({rdReqValid, busy, resValid}), 64'({1'b1, 1'b1, 1'b0}));
    check({req, " R11 addr stable"}, 64'(rdReqAddr), 64'(addr));
    rdReqReady = 1'b1;
    @(negedge clk);
    rdReqReady = 1'b0; inValid = 1'b0;
    check({req, " R11 wait"}, 64'({rdReqValid, busy, resValid}), 64'({1'b0, 1'b1, 1'b0}));
    rdRspValid = 1'b1; rdRspData = data;
    @(negedge clk);
    rdRspValid = 1'b0;
    checkRes(req, 3'd2, 1'b1, data, 1'b0, 32'h0, 1'b0);
    check({req, " R11 idle"}, 64'(busy), 64'(0));
    @(negedge clk);
    check({req, " R11 no ghost"}, 64'(resValid), 64'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", 64'({resValid, busy, rdReqValid, resPc0Valid, resPc1Valid, resUnsupported}),
          64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle no input", 64'({resValid, busy}), 64'(0));

    for (int i = 0; i < NVEC; i++) begin
      logic [117:0] v;
      v = VEC[i];
      @(negedge clk); halfword = v[117:102]; trailWord = v[101:70]; inValid = 1'b1;
      @(negedge clk); inValid = 1'b0;
      checkRes($sformatf("vector %0d (R1 timing)", i), v[69:67], v[66], v[65:34],
               v[33], v[32:1], v[0]);
      check("R1 busy low", 64'(busy), 64'(0));
    end

    // R1 single-cycle strobe, back-to-back accepts
    @(negedge clk); halfword = 16'h0c00; inValid = 1'b1;
    @(negedge clk); halfword = 16'h0100;
    checkRes("R1 b2b first R3", 3'd4, 1'b1, 32'h1004, 1'b0, 32'h0, 1'b0);
    @(negedge clk); inValid = 1'b0;
    checkRes("R1 b2b second R4", 3'd6, 1'b1, 32'h1006, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    check("R1 strobe drops", 64'(resValid), 64'(0));

    deferred("R8 reg jump", 16'h1950, 1'b0, 32'h5, 32'h00004444);
    deferred("R8 reg jump alt", 16'h25f0, 1'b0, 32'hf, 32'h0000a0a0);
    deferred("R9 return", 16'h0400, 1'b1, 32'h8004, 32'h00001234);

    // R11 response before request taken is ignored
    @(negedge clk); halfword = 16'h0400; framePtr = 32'h100; inValid = 1'b1;
    @(negedge clk); inValid = 1'b0; rdRspValid = 1'b1; rdRspData = 32'hbad;
    @(negedge clk); rdRspValid = 1'b0;
    check("R11 early rsp ignored", 64'({rdReqValid, busy, resValid}), 64'({1'b1, 1'b1, 1'b0}));
    check("R9 address fp+4", 64'(rdReqAddr), 64'(32'h104));
    rdReqReady = 1'b1;
    @(negedge clk); rdReqReady = 1'b0; rdRspValid = 1'b1; rdRspData = 32'h7770;
    @(negedge clk); rdRspValid = 1'b0;
    checkRes("R9 late rsp", 3'd2, 1'b1, 32'h7770, 1'b0, 32'h0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule